// File: doc/BRIEF.md
# Class-Steered Issue Window with Reduced Tag Comparators

This block is an out-of-order issue window whose entries are built in three classes. Two-comparator entries can wait on two source tags. One-comparator entries can wait on one source tag. Zero-comparator entries hold only instructions whose operands are all available. The size of each class is a parameter. When an instruction arrives, the allocator looks up both source registers in a one-bit-per-register ready scoreboard. It also looks at the result-tag buses in the same cycle, and it treats an operand the instruction does not use as available. From this it counts how many operands are still in flight. It then places the instruction into the cheapest free entry that has enough comparators. If no entry has enough comparators, it raises a stall to the front end and inserts nothing.

Each entry runs a three-state machine:

- ENT_FREE goes to ENT_REQ when an instruction is loaded with all operands ready, and to ENT_WAIT when it is loaded with operands pending.
- ENT_WAIT goes to ENT_REQ in the cycle after the last pending tag appears on any result bus.
- ENT_REQ goes back to ENT_FREE when the entry is granted.

A fixed-priority select grants the lowest-numbered requesting entry, one per cycle. It drives out that entry's tags, and the entry is released at the same clock edge. Freed entries are reused in any order.

Top module: `tw_window`

## Requirements
- R1: After reset, all entries are free, no issue request is visible, and every scoreboard bit reads as ready.
- R2: Slot numbers are fixed by class. Slots 0 to N2-1 are two-comparator entries, the next N1 slots are one-comparator entries, and the last N0 slots are zero-comparator entries. Within a class, the lowest free slot is chosen.
- R3: An instruction with k operands in flight goes to a free slot of the k-comparator class if one exists. Otherwise it tries the (k+1)-comparator class, and then the two-comparator class. `alloc_done` is high in the cycle of insertion.
- R4: When no free slot of a sufficient class exists, `alloc_stall` is high and `alloc_done` is low. No entry is loaded, and the scoreboard is left unchanged.
- R5: An instruction placed in a zero-comparator slot makes `issue_valid` high in the very next cycle.
- R6: An operand whose use bit is 0 counts as ready whatever its scoreboard bit holds.
- R7: A waiting entry matches its pending tags against all four result buses. It requests issue in the cycle after its last pending tag is broadcast.
- R8: Each cycle, the lowest-numbered requesting slot is granted. `issue_src1`, `issue_src2` and `issue_dst` carry the tags as they were allocated, in operand order. The granted slot is free in the next cycle.
- R9: A broadcast sets the scoreboard bit of its tag. An allocation clears the bit of its destination, and the clear wins over a set of the same register in the same cycle. A tag on a result bus counts as ready for an allocation in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | An instruction is offered for insertion |
| alloc_src1 | input | TAGW | First source register tag |
| alloc_use1 | input | 1 | First source is used |
| alloc_src2 | input | TAGW | Second source register tag |
| alloc_use2 | input | 1 | Second source is used |
| alloc_dst | input | TAGW | Destination register tag |
| alloc_stall | output | 1 | No suitable entry is free; the front end must hold |
| alloc_done | output | 1 | The offered instruction is inserted this cycle |
| alloc_slot | output | SW | Slot chosen for insertion |
| res_valid | input | NBUS | Valid flags of the result-tag buses |
| res_tag | input | NBUS*TAGW | Result tags, with bus b at bits b*TAGW upward |
| issue_valid | output | 1 | A slot is granted this cycle |
| issue_slot | output | SW | Granted slot |
| issue_src1 | output | TAGW | First source tag of the granted instruction |
| issue_src2 | output | TAGW | Second source tag of the granted instruction |
| issue_dst | output | TAGW | Destination tag of the granted instruction |

## Verification
A corrupted entry state shows up at the issue port within one or two cycles, in one of three ways:

- A slot that never requests holds back its dependants.
- A slot that stays in ENT_REQ after its grant is issued a second time in the very next cycle.
- A lost free flag moves later allocations to a different slot, or raises a stall, in the cycle of the next insertion.

A wrong scoreboard bit shows up at the next allocation that reads that register: the instruction lands in a different class of slot. The bench therefore keeps its own shadow of every slot and of the scoreboard, and it compares the chosen slot, the stall and the issued tags every cycle.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_REQ  = 2'd2
    } ent_state_e;
endpackage

// File: rtl/tw_scoreboard.sv
module tw_scoreboard #(
    parameter int PREG = 64,
    parameter int NBUS = 4,
    localparam int TAGW = $clog2(PREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NBUS-1:0]      bus_vld,
    input  logic [NBUS*TAGW-1:0] bus_tag,
    input  logic                 clr_en,
    input  logic [TAGW-1:0]      clr_tag,
    input  logic [TAGW-1:0]      q1_tag,
    input  logic [TAGW-1:0]      q2_tag,
    output logic                 q1_rdy,
    output logic                 q2_rdy
);
    logic [PREG-1:0] sb_q, sb_d;

    function automatic logic on_bus(input logic [TAGW-1:0] t,
                                    input logic [NBUS-1:0] v,
                                    input logic [NBUS*TAGW-1:0] bt);
        logic h;
        h = 1'b0;
        for (int b = 0; b < NBUS; b++)
            if (v[b] && bt[b*TAGW +: TAGW] == t) h = 1'b1;
        return h;
    endfunction

    always_comb begin
        sb_d = sb_q;
        for (int b = 0; b < NBUS; b++)
            if (bus_vld[b]) sb_d[bus_tag[b*TAGW +: TAGW]] = 1'b1;
        if (clr_en) sb_d[clr_tag] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sb_q <= '1;
        else        sb_q <= sb_d;
    end

    assign q1_rdy = sb_q[q1_tag] | on_bus(q1_tag, bus_vld, bus_tag);
    assign q2_rdy = sb_q[q2_tag] | on_bus(q2_tag, bus_vld, bus_tag);
endmodule

// File: rtl/tw_steer.sv
module tw_steer #(
    parameter int N2 = 4,
    parameter int N1 = 4,
    parameter int N0 = 4,
    localparam int N  = N2 + N1 + N0,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0]  free_vec,
    input  logic [1:0]    need,
    output logic          found,
    output logic [SW-1:0] slot
);
    logic          h2, h1, h0;
    logic [SW-1:0] p2, p1, p0;

    always_comb begin
        h2 = 1'b0; h1 = 1'b0; h0 = 1'b0;
        p2 = '0;   p1 = '0;   p0 = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                if (i < N2)           begin h2 = 1'b1; p2 = SW'(i); end
                else if (i < N2 + N1) begin h1 = 1'b1; p1 = SW'(i); end
                else                  begin h0 = 1'b1; p0 = SW'(i); end
            end
        end
    end

    always_comb begin
        found = 1'b0;
        slot  = '0;
        unique case (need)
            2'd0: begin
                if (h0)      begin found = 1'b1; slot = p0; end
                else if (h1) begin found = 1'b1; slot = p1; end
                else if (h2) begin found = 1'b1; slot = p2; end
            end
            2'd1: begin
                if (h1)      begin found = 1'b1; slot = p1; end
                else if (h2) begin found = 1'b1; slot = p2; end
            end
            default: begin
                if (h2)      begin found = 1'b1; slot = p2; end
            end
        endcase
    end
endmodule

// File: rtl/tw_entry.sv
module tw_entry
    import tw_pkg::*;
#(
    parameter int TAGW = 6,
    parameter int NBUS = 4,
    parameter int NCMP = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [TAGW-1:0]      ld_src1,
    input  logic [TAGW-1:0]      ld_src2,
    input  logic [TAGW-1:0]      ld_dst,
    input  logic                 ld_rdy1,
    input  logic                 ld_rdy2,
    input  logic [NBUS-1:0]      bus_vld,
    input  logic [NBUS*TAGW-1:0] bus_tag,
    input  logic                 grant,
    output logic                 req,
    output logic                 busy,
    output logic [TAGW-1:0]      o_src1,
    output logic [TAGW-1:0]      o_src2,
    output logic [TAGW-1:0]      o_dst
);
    ent_state_e      state_q, state_d;
    logic [TAGW-1:0] s1_q, s2_q, d_q;
    logic            r1_q, r2_q;
    logic            hit1, hit2, nr1, nr2;

    function automatic logic snoop(input logic [TAGW-1:0] t,
                                   input logic [NBUS-1:0] v,
                                   input logic [NBUS*TAGW-1:0] bt);
        logic h;
        h = 1'b0;
        for (int b = 0; b < NBUS; b++)
            if (v[b] && bt[b*TAGW +: TAGW] == t) h = 1'b1;
        return h;
    endfunction

    generate
        if (NCMP >= 2) begin : g_two
            assign hit1 = snoop(s1_q, bus_vld, bus_tag);
            assign hit2 = snoop(s2_q, bus_vld, bus_tag);
        end else if (NCMP == 1) begin : g_one
            logic [TAGW-1:0] ctag;
            logic            m;
            assign ctag = r1_q ? s2_q : s1_q;
            assign m    = snoop(ctag, bus_vld, bus_tag);
            assign hit1 = m & ~r1_q;
            assign hit2 = m & r1_q;
        end else begin : g_zero
            assign hit1 = 1'b0;
            assign hit2 = 1'b0;
        end
    endgenerate

    assign nr1 = r1_q | hit1;
    assign nr2 = r2_q | hit2;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: if (load) state_d = (ld_rdy1 && ld_rdy2) ? ENT_REQ : ENT_WAIT;
            ENT_WAIT: if (nr1 && nr2) state_d = ENT_REQ;
            ENT_REQ:  if (grant) state_d = ENT_FREE;
            default:  state_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENT_FREE;
            s1_q <= '0; s2_q <= '0; d_q <= '0;
            r1_q <= 1'b0; r2_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ENT_FREE && load) begin
                s1_q <= ld_src1; s2_q <= ld_src2; d_q <= ld_dst;
                r1_q <= ld_rdy1; r2_q <= ld_rdy2;
            end else if (state_q == ENT_WAIT) begin
                r1_q <= nr1; r2_q <= nr2;
            end
        end
    end

    always_comb begin
        req    = (state_q == ENT_REQ);
        busy   = (state_q != ENT_FREE);
        o_src1 = s1_q;
        o_src2 = s2_q;
        o_dst  = d_q;
    end
endmodule

// File: rtl/tw_select.sv
module tw_select #(
    parameter int N = 12,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0]  req_vec,
    output logic [N-1:0]  gnt_vec,
    output logic          gvalid,
    output logic [SW-1:0] gidx
);
    always_comb begin
        gvalid  = 1'b0;
        gidx    = '0;
        gnt_vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_vec[i]) begin
                gvalid = 1'b1;
                gidx   = SW'(i);
            end
        end
        if (gvalid) gnt_vec[gidx] = 1'b1;
    end
endmodule

// File: rtl/tw_window.sv
module tw_window #(
    parameter int N2   = 4,
    parameter int N1   = 4,
    parameter int N0   = 4,
    parameter int PREG = 64,
    parameter int NBUS = 4,
    localparam int N    = N2 + N1 + N0,
    localparam int TAGW = $clog2(PREG),
    localparam int SW   = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_valid,
    input  logic [TAGW-1:0]      alloc_src1,
    input  logic                 alloc_use1,
    input  logic [TAGW-1:0]      alloc_src2,
    input  logic                 alloc_use2,
    input  logic [TAGW-1:0]      alloc_dst,
    output logic                 alloc_stall,
    output logic                 alloc_done,
    output logic [SW-1:0]        alloc_slot,
    input  logic [NBUS-1:0]      res_valid,
    input  logic [NBUS*TAGW-1:0] res_tag,
    output logic                 issue_valid,
    output logic [SW-1:0]        issue_slot,
    output logic [TAGW-1:0]      issue_src1,
    output logic [TAGW-1:0]      issue_src2,
    output logic [TAGW-1:0]      issue_dst
);
    logic            q1_rdy, q2_rdy, rdy1, rdy2, found;
    logic [1:0]      need;
    logic [N-1:0]    free_vec, req_vec, gnt_vec;
    logic [TAGW-1:0] e_s1 [N];
    logic [TAGW-1:0] e_s2 [N];
    logic [TAGW-1:0] e_d  [N];

    tw_scoreboard #(.PREG(PREG), .NBUS(NBUS)) u_sb (
        .clk(clk), .rst_n(rst_n),
        .bus_vld(res_valid), .bus_tag(res_tag),
        .clr_en(alloc_done), .clr_tag(alloc_dst),
        .q1_tag(alloc_src1), .q2_tag(alloc_src2),
        .q1_rdy(q1_rdy), .q2_rdy(q2_rdy)
    );

    assign rdy1 = ~alloc_use1 | q1_rdy;
    assign rdy2 = ~alloc_use2 | q2_rdy;
    assign need = {1'b0, ~rdy1} + {1'b0, ~rdy2};

    tw_steer #(.N2(N2), .N1(N1), .N0(N0)) u_steer (
        .free_vec(free_vec), .need(need),
        .found(found), .slot(alloc_slot)
    );

    assign alloc_done  = alloc_valid & found;
    assign alloc_stall = alloc_valid & ~found;

    generate
        for (genvar i = 0; i < N; i++) begin : g_ent
            localparam int NC = (i < N2) ? 2 : ((i < N2 + N1) ? 1 : 0);
            logic busy;
            tw_entry #(.TAGW(TAGW), .NBUS(NBUS), .NCMP(NC)) u_ent (
                .clk(clk), .rst_n(rst_n),
                .load(alloc_done && (alloc_slot == SW'(i))),
                .ld_src1(alloc_src1), .ld_src2(alloc_src2), .ld_dst(alloc_dst),
                .ld_rdy1(rdy1), .ld_rdy2(rdy2),
                .bus_vld(res_valid), .bus_tag(res_tag),
                .grant(gnt_vec[i]),
                .req(req_vec[i]), .busy(busy),
                .o_src1(e_s1[i]), .o_src2(e_s2[i]), .o_dst(e_d[i])
            );
            assign free_vec[i] = ~busy;
        end
    endgenerate

    tw_select #(.N(N)) u_sel (
        .req_vec(req_vec), .gnt_vec(gnt_vec),
        .gvalid(issue_valid), .gidx(issue_slot)
    );

    assign issue_src1 = e_s1[issue_slot];
    assign issue_src2 = e_s2[issue_slot];
    assign issue_dst  = e_d[issue_slot];
endmodule

// File: rtl/tw_window_chk.sv
module tw_window_chk #(
    parameter int N2   = 4,
    parameter int N1   = 4,
    parameter int N0   = 4,
    parameter int PREG = 64,
    parameter int NBUS = 4,
    localparam int N    = N2 + N1 + N0,
    localparam int SW   = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          alloc_stall,
    input logic          alloc_done,
    input logic [SW-1:0] alloc_slot,
    input logic          issue_valid,
    input logic [SW-1:0] issue_slot
);
    // R4: a stall never coincides with an insertion
    a_r4_stall_excludes_insert: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |-> !alloc_done);
    // R4: a stall only answers an offered instruction
    a_r4_stall_needs_offer: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |-> alloc_valid);
    // R3: an insertion lands in an existing slot
    a_r3_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_done |-> (int'(alloc_slot) < N));
    // R5: a zero-comparator insertion is followed by an issue
    a_r5_zero_class_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_done && int'(alloc_slot) >= N2 + N1) |=> issue_valid);
    // R8: granted slot is valid
    a_r8_grant_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (int'(issue_slot) < N));
    // R8: a granted slot is released, so it cannot be granted again next cycle
    a_r8_released_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !(issue_valid && issue_slot == $past(issue_slot)));
endmodule

bind tw_window tw_window_chk #(
    .N2(N2), .N1(N1), .N0(N0), .PREG(PREG), .NBUS(NBUS)
) i_chk (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_stall(alloc_stall),
    .alloc_done(alloc_done), .alloc_slot(alloc_slot),
    .issue_valid(issue_valid), .issue_slot(issue_slot)
);

// File: tb/test_tw_window.sv
`timescale 1ns/1ps
module test_tw_window;
    localparam int N2 = 2, N1 = 2, N0 = 2, N = 6, PREG = 16, NBUS = 4, TW = 4, SW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic a_v = 1'b0, a_u1 = 1'b0, a_u2 = 1'b0;
    logic [TW-1:0] a_s1 = '0, a_s2 = '0, a_d = '0;
    logic [NBUS-1:0] r_v = '0;
    logic [NBUS*TW-1:0] r_t = '0;
    logic a_stall, a_done, i_valid;
    logic [SW-1:0] a_slot, i_slot;
    logic [TW-1:0] i_s1, i_s2, i_d;

    int n_chk = 0, n_fail = 0;
    bit done_flag = 1'b0;

    int       m_st [N];
    logic [TW-1:0] m_s1 [N], m_s2 [N], m_d [N];
    bit       m_r1 [N], m_r2 [N];
    bit       m_sb [PREG];

    always #4 clk = ~clk;

    tw_window #(.N2(N2), .N1(N1), .N0(N0), .PREG(PREG), .NBUS(NBUS)) i_tw_window (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(a_v), .alloc_src1(a_s1), .alloc_use1(a_u1),
        .alloc_src2(a_s2), .alloc_use2(a_u2), .alloc_dst(a_d),
        .alloc_stall(a_stall), .alloc_done(a_done), .alloc_slot(a_slot),
        .res_valid(r_v), .res_tag(r_t),
        .issue_valid(i_valid), .issue_slot(i_slot),
        .issue_src1(i_s1), .issue_src2(i_s2), .issue_dst(i_d)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit bus_hit(input logic [TW-1:0] t);
        for (int b = 0; b < NBUS; b++)
            if (r_v[b] && r_t[b*TW +: TW] == t) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int class_of(input int i);
        return (i < N2) ? 2 : ((i < N2 + N1) ? 1 : 0);
    endfunction

    function automatic int exp_slot(input int k);
        for (int c = k; c <= 2; c++)
            for (int i = 0; i < N; i++)
                if (m_st[i] == 0 && class_of(i) == c) return i;
        return -1;
    endfunction

    function automatic int exp_issue();
        for (int i = 0; i < N; i++)
            if (m_st[i] == 2) return i;
        return -1;
    endfunction

    task automatic put(input bit v, input int s1, input bit u1, input int s2, input bit u2, input int d);
        a_v = v; a_s1 = TW'(s1); a_u1 = u1; a_s2 = TW'(s2); a_u2 = u2; a_d = TW'(d);
    endtask

    task automatic bus(input int b, input int t);
        r_v[b] = 1'b1; r_t[b*TW +: TW] = TW'(t);
    endtask

    // one cycle: compare at negedge+2, advance model at posedge
    task automatic tick();
        bit r1, r2;
        int k, es, ei;
        #2;
        r1 = !a_u1 || m_sb[a_s1] || bus_hit(a_s1);
        r2 = !a_u2 || m_sb[a_s2] || bus_hit(a_s2);
        k  = (r1 ? 0 : 1) + (r2 ? 0 : 1);
        es = a_v ? exp_slot(k) : -1;
        ei = exp_issue();
        chk("R4 stall", int'(a_stall), (a_v && es < 0) ? 1 : 0);
        chk("R3 done", int'(a_done), (es >= 0) ? 1 : 0);
        if (es >= 0) chk("R3 slot", int'(a_slot), es);
        chk("R7 issue_valid", int'(i_valid), (ei >= 0) ? 1 : 0);
        if (ei >= 0) begin
            chk("R8 issue_slot", int'(i_slot), ei);
            chk("R8 issue_src1", int'(i_s1), int'(m_s1[ei]));
            chk("R8 issue_src2", int'(i_s2), int'(m_s2[ei]));
            chk("R8 issue_dst", int'(i_d), int'(m_d[ei]));
        end
        @(posedge clk);
        if (ei >= 0) m_st[ei] = 0;
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 1) begin
                if (!m_r1[i] && bus_hit(m_s1[i])) m_r1[i] = 1'b1;
                if (!m_r2[i] && bus_hit(m_s2[i])) m_r2[i] = 1'b1;
                if (m_r1[i] && m_r2[i]) m_st[i] = 2;
            end
        end
        for (int b = 0; b < NBUS; b++)
            if (r_v[b]) m_sb[r_t[b*TW +: TW]] = 1'b1;
        if (es >= 0) begin
            m_sb[a_d] = 1'b0;
            m_st[es] = (r1 && r2) ? 2 : 1;
            m_s1[es] = a_s1; m_s2[es] = a_s2; m_d[es] = a_d;
            m_r1[es] = r1;   m_r2[es] = r2;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) begin
            put(0, 0, 0, 0, 0, 0); r_v = '0;
            tick();
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired, actual running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7296));
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_s1[i] = '0; m_s2[i] = '0; m_d[i] = '0; m_r1[i] = 0; m_r2[i] = 0;
        end
        for (int i = 0; i < PREG; i++) m_sb[i] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 no request after reset", int'(i_valid), 0);
        chk("R1 no stall after reset", int'(a_stall), 0);
        idle(1);

        // A: both ready -> lowest zero-comparator slot (index N2+N1)
        put(1, 1, 1, 2, 1, 10); r_v = '0; #1;
        chk("R2 first zero slot", int'(a_slot), 4);
        tick();
        // B: one pending (reg 10), second unused
        put(1, 10, 1, 10, 0, 11); #1;
        chk("R5 zero-slot request next cycle", int'(i_valid), 1);
        chk("R5 zero-slot granted", int'(i_slot), 4);
        chk("R6 one pending, unused ignored", int'(a_slot), 2);
        tick();
        // C: two pending
        put(1, 10, 1, 10, 1, 12); #1;
        chk("R3 two pending to two-comparator slot", int'(a_slot), 0);
        tick();
        // D: neither operand used although reg 10 is not ready
        put(1, 10, 0, 10, 0, 13); #1;
        chk("R6 unused operands count ready", int'(a_slot), 4);
        tick();
        // E: reg 10 on bus 2 this cycle -> counts ready
        put(1, 10, 1, 10, 1, 14); bus(2, 10); #1;
        chk("R9 same-cycle broadcast bypass", int'(a_slot), 5);
        tick();
        put(0, 0, 0, 0, 0, 0); r_v = '0; #1;
        chk("R7 woken entry requests next cycle", int'(i_valid), 1);
        chk("R8 lowest requester first", int'(i_slot), 0);
        chk("R8 issued dst", int'(i_d), 12);
        tick();
        idle(4);
        // F: writes reg 7 while bus broadcasts 7: clear wins
        put(1, 1, 1, 2, 1, 7); bus(0, 7); tick();
        idle(3);
        put(1, 7, 1, 3, 0, 8); #1;
        chk("R9 clear beats set", int'(a_slot), 2);
        tick();
        put(1, 7, 1, 3, 0, 5); #1;
        chk("R3 exact class", int'(a_slot), 3);
        tick();
        put(1, 3, 0, 7, 1, 6); #1;
        chk("R3 fallback to richer class", int'(a_slot), 0);
        tick();
        put(1, 7, 1, 7, 1, 4); #1;
        chk("R3 two pending", int'(a_slot), 1);
        tick();
        put(1, 7, 1, 7, 1, 9); #1;
        chk("R4 stall raised", int'(a_stall), 1);
        chk("R4 nothing inserted", int'(a_done), 0);
        tick();
        put(1, 9, 1, 9, 1, 15); #1;
        chk("R4 stalled dst left ready", int'(a_slot), 4);
        tick();
        put(0, 0, 0, 0, 0, 0); r_v = '0; bus(3, 7); tick();
        r_v = '0; #1;
        chk("R7 bus 3 wakes waiting slots", int'(i_slot), 0);
        tick();
        idle(6);

        // constrained random phase
        for (int c = 0; c < 4000; c++) begin
            a_v  = ($urandom % 4) != 0;
            a_s1 = TW'($urandom % PREG);
            a_s2 = TW'($urandom % PREG);
            a_d  = TW'($urandom % PREG);
            a_u1 = ($urandom % 4) != 0;
            a_u2 = ($urandom % 4) != 0;
            for (int b = 0; b < NBUS; b++) begin
                r_v[b] = ($urandom % 4) == 0;
                r_t[b*TW +: TW] = TW'($urandom % PREG);
            end
            tick();
        end
        idle(2);
        finish_run();
    end
endmodule